// File: doc/BRIEF.md
# Serial Command Frame Decoder

The decoder takes a byte stream from a host link, one byte per cycle whenever `in_valid` is high. It groups the bytes into fixed command frames of 112 bytes. When the last byte of a frame arrives, that byte selects what happens to the frame.

There are three outcomes:

- **Global frame.** The decoder updates an 8-byte global configuration register.
- **Cluster frame.** The decoder loads the active-core mask and the nonce start offset of one cluster.
- **Work frame.** Every other frame is a work frame. Its byte-reversed payload is put back into natural order as an 80-byte header and an 8-byte target. These are presented to the hashing engine with a one-cycle strobe.

A synchronous `clear` input drops a partly received frame, so that a board reset on the host side puts the frame boundary back in line.

The return path takes result records from the engine. Each record is a nonce, a core id and a cluster id. Records are held in a small queue and sent back to the host as 8-byte records, one byte per accepted transfer on a valid/ready pair.

Top module: `cmd_frame_decoder`

## Requirements
- R1: A frame is complete on the 112th byte accepted with `in_valid` high since reset, since `clear`, or since the previous frame. Cycles with `in_valid` low add nothing.
- R2: If the final byte is 0xFF, `glb_reg[8k+7:8k]` takes frame byte 102+k for k = 0..7. The value is visible the cycle after the final byte is accepted, and the other outputs keep their values.
- R3: If the final byte is 0xFE and byte 110 (the cluster id c) is below NUM_CLUSTERS, two fields of cluster c are loaded and all other clusters keep their values:
  - `clu_mask[16c+15:16c]` takes {byte 104, byte 105}.
  - `clu_offset[32c+31:32c]` takes {byte 104+2 .. byte 109}, most significant byte first, that is {byte 106, byte 107, byte 108, byte 109}.
- R4: Any other final byte makes a work frame, and the global and cluster registers are left unchanged:
  - `work_header[8i+7:8i]` takes frame byte 79-i for i = 0..79.
  - `work_target[8j+7:8j]` takes frame byte 87-j for j = 0..7.
- R5: `work_valid` is high for exactly the one cycle after the final byte of a work frame is accepted, and it is never high otherwise.
- R6: A 0xFE frame whose cluster id is NUM_CLUSTERS or more changes no mask or offset. It sets `clu_err`, which stays high until reset.
- R7: When `clear` is high, any partial frame is discarded, and the next accepted byte is byte 0 of a new frame.
- R8: After reset every register output is zero, `work_valid` and `tx_valid` are low, and `res_ready` is high.
- R9: A result record goes out as 8 bytes in this order: nonce[31:24], nonce[23:16], nonce[15:8], nonce[7:0], 0x00, 0x00, core id, cluster id. Each byte is transferred on a cycle with `tx_valid` and `tx_ready` both high, and `tx_data` holds steady while `tx_ready` is low.
- R10: Up to RES_DEPTH records wait in arrival order. `res_ready` is low exactly when RES_DEPTH records are held, and a record offered while it is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous abort of a partial frame |
| in_valid | input | 1 | Host byte present |
| in_data | input | 8 | Host byte |
| glb_reg | output | 64 | Global configuration register, byte k at bits 8k+7:8k |
| clu_mask | output | 16*NUM_CLUSTERS | Active-core mask for each cluster |
| clu_offset | output | 32*NUM_CLUSTERS | Nonce start offset for each cluster |
| clu_err | output | 1 | Sticky flag for an out-of-range cluster id |
| work_valid | output | 1 | One-cycle strobe marking a new work item |
| work_header | output | 640 | Work header in natural byte order |
| work_target | output | 64 | Work target in natural byte order |
| res_valid | input | 1 | Result record offered |
| res_nonce | input | 32 | Result nonce |
| res_core | input | 8 | Result core id |
| res_cluster | input | 8 | Result cluster id |
| res_ready | output | 1 | Room for a result record |
| tx_valid | output | 1 | Outgoing record byte present |
| tx_data | output | 8 | Outgoing record byte |
| tx_ready | input | 1 | Host accepts the byte |

## Verification
A byte counter that drifts by one shows up immediately as a broken frame boundary. The next frame's final byte is then taken from the wrong position, so a global write produces no register change or a spurious `work_valid`, and this is visible one cycle after the 112th byte. A wrong byte index in the reassembly is caught one cycle after the frame ends, by comparing every byte of the header, target, mask and offset against the sent pattern. On the return path, a wrong pointer or byte index shows up as a wrong, repeated or missing byte within the record being drained, and a wrong occupancy count shows up as `res_ready` changing on the wrong push.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int FRAME_BYTES = 112;
  localparam int HDR_BYTES   = 80;
  localparam int TGT_BYTES   = 8;
  localparam int LO_BYTES    = HDR_BYTES + TGT_BYTES;
  localparam int HI_START    = 102;
  localparam int HI_BYTES    = FRAME_BYTES - HI_START;
  localparam int GLB_BYTES   = 8;
  localparam int REC_BYTES   = 8;
  // byte positions inside the upper window (frame byte minus HI_START)
  localparam int HI_GLB  = 0;
  localparam int HI_MASK = 2;
  localparam int HI_OFF  = 4;
  localparam int HI_CID  = 8;
  localparam int HI_KIND = 9;
  localparam logic [7:0] KIND_GLB = 8'hFF;
  localparam logic [7:0] KIND_CLU = 8'hFE;
endpackage

// File: rtl/cfd_frame_asm.sv
module cfd_frame_asm
  import cfd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    frame_done,
  output logic [8*LO_BYTES-1:0]   lo_bytes,
  output logic [8*HI_BYTES-1:0]   hi_bytes
);
  localparam int CW = $clog2(FRAME_BYTES);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BYTES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          take;

  assign take       = in_valid && !clear;
  assign frame_done = take && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)         cnt_d = '0;
    else if (in_valid) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Only bytes that some frame type decodes are stored; the final byte is
  // taken straight from the input in the cycle it arrives.
  for (genvar k = 0; k < FRAME_BYTES - 1; k++) begin : g_byte
    if (k < LO_BYTES || k >= HI_START) begin : g_keep
      logic [7:0] b_q;
      logic       en;
      assign en = take && (cnt_q == CW'(k));
      always_ff @(posedge clk) begin
        if (en) b_q <= in_data;
      end
      if (k < LO_BYTES) begin : g_lo
        assign lo_bytes[8*k +: 8] = b_q;
      end else begin : g_hi
        assign hi_bytes[8*(k-HI_START) +: 8] = b_q;
      end
    end
  end

  assign hi_bytes[8*(HI_BYTES-1) +: 8] = in_data;
endmodule

// File: rtl/cfd_dispatch.sv
module cfd_dispatch
  import cfd_pkg::*;
#(
  parameter int NUM_CLUSTERS = 6
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_done,
  input  logic [8*LO_BYTES-1:0]       lo_bytes,
  input  logic [8*HI_BYTES-1:0]       hi_bytes,
  output logic [8*GLB_BYTES-1:0]      glb_reg,
  output logic [16*NUM_CLUSTERS-1:0]  clu_mask,
  output logic [32*NUM_CLUSTERS-1:0]  clu_offset,
  output logic                        clu_err,
  output logic                        work_valid,
  output logic [8*HDR_BYTES-1:0]      work_header,
  output logic [8*TGT_BYTES-1:0]      work_target
);
  localparam logic [7:0] NC8 = 8'(NUM_CLUSTERS);

  logic [7:0]               kind, cid;
  logic                     is_glb, is_clu, is_work, cid_ok;
  logic [15:0]              mask_new;
  logic [31:0]              off_new;
  logic [8*HDR_BYTES-1:0]   hdr_new;
  logic [8*TGT_BYTES-1:0]   tgt_new;
  logic                     err_d;

  assign kind    = hi_bytes[8*HI_KIND +: 8];
  assign cid     = hi_bytes[8*HI_CID  +: 8];
  assign is_glb  = frame_done && (kind == KIND_GLB);
  assign is_clu  = frame_done && (kind == KIND_CLU);
  assign is_work = frame_done && (kind != KIND_GLB) && (kind != KIND_CLU);
  assign cid_ok  = cid < NC8;

  assign mask_new = {hi_bytes[8*HI_MASK +: 8], hi_bytes[8*(HI_MASK+1) +: 8]};
  assign off_new  = {hi_bytes[8*HI_OFF +: 8],     hi_bytes[8*(HI_OFF+1) +: 8],
                     hi_bytes[8*(HI_OFF+2) +: 8], hi_bytes[8*(HI_OFF+3) +: 8]};

  // undo the byte reversal of the work payload
  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_hdr
    assign hdr_new[8*i +: 8] = lo_bytes[8*(HDR_BYTES-1-i) +: 8];
  end
  for (genvar j = 0; j < TGT_BYTES; j++) begin : g_tgt
    assign tgt_new[8*j +: 8] = lo_bytes[8*(LO_BYTES-1-j) +: 8];
  end

  assign err_d = clu_err || (is_clu && !cid_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_reg     <= '0;
      clu_err     <= 1'b0;
      work_valid  <= 1'b0;
      work_header <= '0;
      work_target <= '0;
    end else begin
      clu_err    <= err_d;
      work_valid <= is_work;
      if (is_glb) glb_reg <= hi_bytes[8*HI_GLB +: 8*GLB_BYTES];
      if (is_work) begin
        work_header <= hdr_new;
        work_target <= tgt_new;
      end
    end
  end

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_clu
    logic en;
    assign en = is_clu && cid_ok && (cid == 8'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clu_mask[16*c +: 16]   <= '0;
        clu_offset[32*c +: 32] <= '0;
      end else if (en) begin
        clu_mask[16*c +: 16]   <= mask_new;
        clu_offset[32*c +: 32] <= off_new;
      end
    end
  end
endmodule

// File: rtl/cfd_result_ser.sv
module cfd_result_ser
  import cfd_pkg::*;
#(
  parameter int DEPTH = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        res_valid,
  input  logic [31:0] res_nonce,
  input  logic [7:0]  res_core,
  input  logic [7:0]  res_cluster,
  output logic        res_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int BW   = $clog2(REC_BYTES);
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL     = CNTW'(DEPTH);
  localparam logic [BW-1:0]   B_LAST   = BW'(REC_BYTES - 1);

  logic [8*REC_BYTES-1:0] mem [DEPTH];
  logic [8*REC_BYTES-1:0] rec_in;
  logic [AW-1:0]          wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNTW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]          bidx_q, bidx_d;
  logic                   push, xfer, pop;

  // byte b of the record sits at bits 8b+7:8b
  assign rec_in = {res_cluster, res_core, 8'h00, 8'h00,
                   res_nonce[7:0], res_nonce[15:8], res_nonce[23:16], res_nonce[31:24]};

  assign res_ready = (cnt_q != FULL);
  assign tx_valid  = (cnt_q != '0);
  assign push      = res_valid && res_ready;
  assign xfer      = tx_valid && tx_ready;
  assign pop       = xfer && (bidx_q == B_LAST);
  assign tx_data   = mem[rptr_q][{bidx_q, 3'b000} +: 8];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    bidx_d = bidx_q;
    if (push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
    if (xfer) bidx_d = (bidx_q == B_LAST) ? '0 : bidx_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      bidx_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= rec_in;
  end
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
  import cfd_pkg::*;
#(
  parameter int NUM_CLUSTERS = 6,
  parameter int RES_DEPTH    = 4
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        in_valid,
  input  logic [7:0]                  in_data,
  output logic [8*GLB_BYTES-1:0]      glb_reg,
  output logic [16*NUM_CLUSTERS-1:0]  clu_mask,
  output logic [32*NUM_CLUSTERS-1:0]  clu_offset,
  output logic                        clu_err,
  output logic                        work_valid,
  output logic [8*HDR_BYTES-1:0]      work_header,
  output logic [8*TGT_BYTES-1:0]      work_target,
  input  logic                        res_valid,
  input  logic [31:0]                 res_nonce,
  input  logic [7:0]                  res_core,
  input  logic [7:0]                  res_cluster,
  output logic                        res_ready,
  output logic                        tx_valid,
  output logic [7:0]                  tx_data,
  input  logic                        tx_ready
);
  logic [1:0]              rs_q;
  logic                    rst_int_n;
  logic                    frame_done;
  logic [8*LO_BYTES-1:0]   lo_bytes;
  logic [8*HI_BYTES-1:0]   hi_bytes;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  cfd_frame_asm u_asm (
    .clk(clk), .rst_n(rst_int_n), .clear(clear), .in_valid(in_valid),
    .in_data(in_data), .frame_done(frame_done), .lo_bytes(lo_bytes),
    .hi_bytes(hi_bytes)
  );

  cfd_dispatch #(.NUM_CLUSTERS(NUM_CLUSTERS)) u_disp (
    .clk(clk), .rst_n(rst_int_n), .frame_done(frame_done),
    .lo_bytes(lo_bytes), .hi_bytes(hi_bytes), .glb_reg(glb_reg),
    .clu_mask(clu_mask), .clu_offset(clu_offset), .clu_err(clu_err),
    .work_valid(work_valid), .work_header(work_header),
    .work_target(work_target)
  );

  cfd_result_ser #(.DEPTH(RES_DEPTH)) u_ser (
    .clk(clk), .rst_n(rst_int_n), .res_valid(res_valid),
    .res_nonce(res_nonce), .res_core(res_core), .res_cluster(res_cluster),
    .res_ready(res_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready)
  );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker
  import cfd_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clear,
  input logic                    in_valid,
  input logic [8*GLB_BYTES-1:0]  glb_reg,
  input logic                    clu_err,
  input logic                    work_valid,
  input logic [8*HDR_BYTES-1:0]  work_header,
  input logic                    res_ready,
  input logic                    tx_valid,
  input logic [7:0]              tx_data,
  input logic                    tx_ready
);
  // R2: the global register moves only right after an accepted byte
  a_r2_glb_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(glb_reg) |-> ($past(in_valid) && !$past(clear)));

  // R4: the header moves only together with the work strobe
  a_r4_hdr_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(work_header) |-> work_valid);

  // R5: the strobe lasts one cycle
  a_r5_work_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    work_valid |=> !work_valid);

  // R6: error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    clu_err |=> clu_err);

  // R9: a stalled byte is held
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R10: a full queue always has something to send
  a_r10_full_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready |-> tx_valid);
endmodule

bind cmd_frame_decoder cfd_checker u_chk (.*);

// File: tb/cmd_frame_decoder_bench.sv
module cmd_frame_decoder_bench;
  localparam int NC = 6;
  localparam int RD = 4;

  logic clk, rst_n, clear, in_valid;
  logic [7:0] in_data;
  logic [63:0] glb_reg;
  logic [16*NC-1:0] clu_mask;
  logic [32*NC-1:0] clu_offset;
  logic clu_err, work_valid;
  logic [639:0] work_header;
  logic [63:0] work_target;
  logic res_valid;
  logic [31:0] res_nonce;
  logic [7:0] res_core, res_cluster;
  logic res_ready, tx_valid, tx_ready;
  logic [7:0] tx_data;

  cmd_frame_decoder #(.NUM_CLUSTERS(NC), .RES_DEPTH(RD)) u_cmd_frame_decoder (.*);

  int n_chk = 0, n_bad = 0, wv_cnt = 0, rx_n = 0, rc = 0, rdy_mode = 0;
  bit done = 0;
  logic [7:0] fr [112];
  logic [7:0] rx [64];
  logic [15:0] em [NC];
  logic [31:0] eo [NC];

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [1023:0] act, input logic [1023:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (work_valid) wv_cnt++;
    case (rdy_mode)
      0: tx_ready = 1'b0;
      1: tx_ready = 1'b1;
      default: tx_ready = (rc % 3 == 0);
    endcase
    rc++;
    if (tx_valid && tx_ready && rx_n < 64) begin
      rx[rx_n] = tx_data;
      rx_n++;
    end
  end

  task automatic send_frame(input int gap, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      @(negedge clk); in_valid = 1'b1; in_data = fr[k];
      if (gap != 0 && k < nbytes - 1) begin
        @(negedge clk); in_valid = 1'b0; in_data = 8'h5A;
      end
    end
    @(negedge clk); in_valid = 1'b0;
    #1;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic check_clusters(input string tag);
    for (int c = 0; c < NC; c++) begin
      check(tag, clu_mask[16*c +: 16], em[c]);
      check(tag, clu_offset[32*c +: 32], eo[c]);
    end
  endtask

  function automatic logic [7:0] rbyte(input logic [31:0] n, input logic [7:0] co,
                                       input logic [7:0] cl, input int b);
    case (b)
      0: return n[31:24];
      1: return n[23:16];
      2: return n[15:8];
      3: return n[7:0];
      6: return co;
      7: return cl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic push_rec(input logic [31:0] n, input logic [7:0] co, input logic [7:0] cl);
    @(negedge clk);
    res_valid = 1'b1; res_nonce = n; res_core = co; res_cluster = cl;
  endtask

  logic [63:0] eg;
  logic [639:0] eh;
  logic [63:0] et;
  int w0;
  logic [31:0] rn [5];
  logic [7:0] rco [5];
  logic [7:0] rcl [5];
  logic [7:0] held;

  initial begin
    rst_n = 0; clear = 0; in_valid = 0; in_data = 0; res_valid = 0;
    res_nonce = 0; res_core = 0; res_cluster = 0; tx_ready = 0;
    for (int c = 0; c < NC; c++) begin em[c] = 0; eo[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    check("R8 glb", glb_reg, 64'h0);
    check_clusters("R8 clu");
    check("R8 err", clu_err, 0);
    check("R8 wv", work_valid, 0);
    check("R8 hdr", work_header, 0);
    check("R8 tx_valid", tx_valid, 0);
    check("R8 res_ready", res_ready, 1);

    // R2 global frame, padding filled with junk
    for (int k = 0; k < 112; k++) fr[k] = 8'((k * 13 + 1) & 8'hFF);
    for (int k = 0; k < 8; k++) begin fr[102+k] = 8'(8'h30 + 17*k); eg[8*k +: 8] = fr[102+k]; end
    fr[110] = 0; fr[111] = 8'hFF;
    w0 = wv_cnt;
    send_frame(0, 112);
    check("R2 glb", glb_reg, eg);
    check("R2 no work strobe", wv_cnt - w0, 0);
    check_clusters("R2 clusters untouched");

    // R3 sweep over every cluster id, R1 with idle gaps on odd ids
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 112; k++) fr[k] = 8'(8'hC3 ^ k);
      em[c] = 16'(16'h1357 * (c + 1));
      eo[c] = 32'(32'h0123_4567 * (c + 3) + c);
      fr[104] = em[c][15:8]; fr[105] = em[c][7:0];
      fr[106] = eo[c][31:24]; fr[107] = eo[c][23:16];
      fr[108] = eo[c][15:8];  fr[109] = eo[c][7:0];
      fr[110] = 8'(c); fr[111] = 8'hFE;
      send_frame(c % 2, 112);
      check_clusters("R3 cluster load");
    end
    check("R3 glb kept", glb_reg, eg);
    check("R6 no err yet", clu_err, 0);

    // R6 bad cluster ids
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 112; k++) fr[k] = 8'hAA;
      fr[110] = (t == 0) ? 8'd6 : 8'd200; fr[111] = 8'hFE;
      send_frame(0, 112);
      check("R6 err set", clu_err, 1);
      check_clusters("R6 drop");
    end

    // R4/R5 work frame
    for (int k = 0; k < 112; k++) fr[k] = 0;
    for (int i = 0; i < 80; i++) begin fr[79-i] = 8'((i * 7 + 3) & 8'hFF); eh[8*i +: 8] = fr[79-i]; end
    for (int j = 0; j < 8; j++) begin fr[87-j] = 8'(8'hA0 + j); et[8*j +: 8] = fr[87-j]; end
    w0 = wv_cnt;
    send_frame(0, 112);
    check("R5 strobe", work_valid, 1);
    check("R4 header", work_header, eh);
    check("R4 target", work_target, et);
    @(negedge clk); #1;
    check("R5 single cycle", work_valid, 0);
    check("R5 count", wv_cnt - w0, 1);
    check("R4 glb kept", glb_reg, eg);
    check_clusters("R4 clusters kept");
    check("R6 sticky", clu_err, 1);

    // R4 scan-style frame: all-ones target area, final byte zero
    for (int i = 0; i < 80; i++) begin fr[79-i] = 8'(8'hF0 - i); eh[8*i +: 8] = fr[79-i]; end
    for (int k = 80; k < 111; k++) fr[k] = 8'hFF;
    fr[111] = 0;
    send_frame(1, 112);
    check("R4 scan header", work_header, eh);
    check("R4 scan target", work_target, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7 clear aborts a partial frame
    for (int k = 0; k < 112; k++) fr[k] = 8'hFF;
    send_frame(0, 50);
    pulse_clear();
    for (int k = 0; k < 112; k++) fr[k] = 0;
    for (int k = 0; k < 8; k++) begin fr[102+k] = 8'(8'h91 + 5*k); eg[8*k +: 8] = fr[102+k]; end
    fr[111] = 8'hFF;
    w0 = wv_cnt;
    send_frame(0, 112);
    check("R7 realigned glb", glb_reg, eg);
    check("R7 no stray work", wv_cnt - w0, 0);

    // R1 a frame one byte short loads nothing
    for (int k = 0; k < 112; k++) fr[k] = 8'h11;
    send_frame(0, 111);
    repeat (2) @(negedge clk); #1;
    check("R1 short frame", glb_reg, eg);
    pulse_clear();

    // R10 fill queue with transmitter stalled
    rdy_mode = 0; rx_n = 0;
    for (int r = 0; r < 5; r++) begin
      rn[r] = 32'h1000_0001 * (r + 1) + 32'h00A5_5A00;
      rco[r] = 8'(r + 2); rcl[r] = 8'(5 - r);
    end
    for (int r = 0; r < 5; r++) begin
      push_rec(rn[r], rco[r], rcl[r]);
      #1;
      check("R10 ready level", res_ready, (r < 4) ? 1 : 0);
    end
    @(negedge clk); res_valid = 0;
    held = tx_data;
    repeat (3) @(negedge clk); #1;
    check("R9 first byte", held, rn[0][31:24]);
    check("R9 held", tx_data, held);
    rdy_mode = 1;
    repeat (45) @(negedge clk); #1;
    check("R10 drop when full", rx_n, 32);
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 8; b++)
        check("R9 byte order", rx[8*r+b], rbyte(rn[r], rco[r], rcl[r], b));
    check("R10 drained", tx_valid, 0);
    check("R10 ready again", res_ready, 1);

    // R9 back-to-back records with sparse ready
    rdy_mode = 2; rx_n = 0;
    for (int r = 0; r < 3; r++) push_rec(32'hDEAD_0000 + 32'(r * 32'h111), 8'(8 - r), 8'(r));
    @(negedge clk); res_valid = 0;
    repeat (90) @(negedge clk); #1;
    check("R9 count sparse", rx_n, 24);
    for (int r = 0; r < 3; r++)
      for (int b = 0; b < 8; b++)
        check("R9 sparse bytes", rx[8*r+b],
              rbyte(32'hDEAD_0000 + 32'(r * 32'h111), 8'(8 - r), 8'(r), b));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule